// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer with Selectable Postscaler

This block is a watchdog that runs on a free-running internal low-frequency oscillator clock. A binary base divider of 2^BASE_LOG2 cycles (128 by default, about 4 ms) produces a base tick. A postscaler counts those ticks, and a select code chooses after how many ticks, 2^code, the period ends. The full default range runs from one base period up to 32,768 base periods, roughly 135 s. If software fails to restart the count in time, the block asks for a device reset while the chip is awake, or for a wake-up while it is asleep. A sticky flag records that a timeout happened.

The watchdog is on when either the fixed configuration enable or the software enable is set. Software can therefore turn it on but never off once configuration has turned it on. Both counters restart on a software clear strobe, on sleep entry, while a clock-failure flag is raised, on device reset and after every timeout. A new select code is taken only when the counters restart, so a period that is already running is never cut short.

Top module: `lfo_watchdog`

## Requirements
- R1: The watchdog is enabled when `cfg_en` OR `sw_en` is 1. `osc_en` shows the effective enable one cycle after the inputs change. With `cfg_en`=1, clearing `sw_en` does not disable it.
- R2: While disabled, both counters are held at zero and neither `rst_req` nor `wake_req` is ever raised.
- R3: With select code s, the period is P = 2^BASE_LOG2 * 2^s clock cycles. If the counters restart at clock edge k, the first timeout pulse is visible in the cycle after edge k+P. Enabling also counts as a restart, at the first edge that samples the enable.
- R4: A 1 on `clr_strobe` at an edge restarts the period from that edge.
- R5: A 1 on `sleep_enter` at an edge restarts the period from that edge.
- R6: While `clk_fail` is 1, the counters stay cleared and no request is made. Counting resumes from the last edge that sampled it high.
- R7: A timeout raises `rst_req` for exactly one cycle when `in_sleep`=0 at the expiry edge. It raises `wake_req` for exactly one cycle instead when `in_sleep`=1. The two are never high together.
- R8: After a timeout, the counters restart from that expiry edge, so free-running timeouts repeat every P cycles.
- R9: A change of `tap_sel` takes effect only at the next restart. A running period finishes with the old code.
- R10: `timeout_flag` sets on every timeout and stays set. It clears on `flag_clr` or on `rst` with `rst_src_wdt`=0. It holds through `rst` with `rst_src_wdt`=1. A timeout in the same cycle as `flag_clr` leaves it set.
- R11: `rst` clears the counters, the requests and the effective enable. Counting restarts at the first edge after `rst` is released.
- R12: A restart condition at the same edge as an expiry suppresses that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Low-frequency oscillator clock |
| rst | input | 1 | Synchronous active-high device reset |
| rst_src_wdt | input | 1 | Current reset was caused by this watchdog |
| cfg_en | input | 1 | Fixed configuration enable |
| sw_en | input | 1 | Software enable |
| tap_sel | input | SEL_W | Postscaler select code, ratio 2^code |
| clr_strobe | input | 1 | Software clear of both counters |
| sleep_enter | input | 1 | Sleep-entry strobe, clears both counters |
| clk_fail | input | 1 | Clock-failure flag, holds counters cleared |
| in_sleep | input | 1 | Device is in a power-managed sleep mode |
| flag_clr | input | 1 | Clears the timeout flag |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| timeout_flag | output | 1 | Sticky timeout status |
| osc_en | output | 1 | Effective enable, also keeps the oscillator running |

## Verification
The bench sweeps every select code in both awake and sleep states, and counts cycles to predict each pulse exactly. An off-by-one divider or tap decode would show up as a shifted pulse. The bench changes the select code in the middle of a period: a live decode would cut that period short instead of finishing it with the old code. It also places a clear exactly on the expiry edge and raises `flag_clr` on a timeout edge, so wrong priorities there show up as a stray request or a lost flag. Finally, it resets with and without the watchdog-cause qualifier, which exposes a flag that is wiped or kept on the wrong kind of reset.

// File: rtl/lfo_wdt_pkg.sv
package lfo_wdt_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_WAKE  = 2'd2
  } wdt_event_e;

  typedef struct packed {
    logic soft_clr;
    logic sleep_in;
    logic osc_fail;
  } clr_src_t;

  function automatic logic any_clear(input clr_src_t s);
    return s.soft_clr | s.sleep_in | s.osc_fail;
  endfunction

endpackage

// File: rtl/wdt_enable_ctl.sv
module wdt_enable_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_en,
  input  logic sw_en,
  output logic run
);

  // Software may only add to the configuration enable, never remove it.
  always_ff @(posedge clk) begin
    if (rst) run <= 1'b0;
    else     run <= cfg_en | sw_en;
  end

endmodule

// File: rtl/wdt_base_div.sv
module wdt_base_div #(
  parameter int BASE_LOG2 = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);

  logic [BASE_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt + BASE_LOG2'(1);
  end

  // Last count of the base period.
  assign tick = &cnt;

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             hit
);

  localparam int NTAP  = 2 ** SEL_W;
  localparam int POST_W = NTAP - 1;

  logic [POST_W-1:0] cnt;
  logic [SEL_W-1:0]  sel_q;
  logic [NTAP-1:0]   tap_ok;

  // The select code is captured only when the counters restart.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      sel_q <= tap_sel;
    end else if (tick) begin
      cnt <= cnt + POST_W'(1);
    end
  end

  // Tap i is reached when the low i bits of the count are all ones.
  genvar gi;
  generate
    for (gi = 0; gi < NTAP; gi++) begin : g_tap
      if (gi == 0) begin : g_first
        assign tap_ok[gi] = 1'b1;
      end else begin : g_rest
        assign tap_ok[gi] = &cnt[gi-1:0];
      end
    end
  endgenerate

  assign hit = tick & tap_ok[sel_q];

  // R3: the count never climbs past the span of the captured tap.
  p_cnt_in_span_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt & ~((POST_W'(1) << sel_q) - POST_W'(1))) == '0)
    else $error("postscaler count exceeded selected span");

endmodule

// File: rtl/wdt_event_gen.sv
module wdt_event_gen
  import lfo_wdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rst_src_wdt,
  input  logic expire,
  input  logic in_sleep,
  input  logic flag_clr,
  output logic rst_req,
  output logic wake_req,
  output logic timeout_flag
);

  wdt_event_e ev;

  always_comb begin
    if (!expire)       ev = EV_NONE;
    else if (in_sleep) ev = EV_WAKE;
    else               ev = EV_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      if (!rst_src_wdt) timeout_flag <= 1'b0;
    end else begin
      rst_req  <= (ev == EV_RESET);
      wake_req <= (ev == EV_WAKE);
      if (ev != EV_NONE)  timeout_flag <= 1'b1;
      else if (flag_clr)  timeout_flag <= 1'b0;
    end
  end

  // R7: requests are single-cycle pulses.
  p_rst_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req) else $error("reset request longer than one cycle");
  p_wake_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wake_req |=> !wake_req) else $error("wake request longer than one cycle");
  // R7: never both kinds of request at once.
  p_req_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req)) else $error("reset and wake requested together");
  // R10: a request is always accompanied by the sticky flag.
  p_flag_with_req_r10: assert property (@(posedge clk) disable iff (rst)
    (rst_req || wake_req) |-> timeout_flag) else $error("flag missing on timeout");

endmodule

// File: rtl/lfo_watchdog.sv
module lfo_watchdog
  import lfo_wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 7,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_src_wdt,
  input  logic             cfg_en,
  input  logic             sw_en,
  input  logic [SEL_W-1:0] tap_sel,
  input  logic             clr_strobe,
  input  logic             sleep_enter,
  input  logic             clk_fail,
  input  logic             in_sleep,
  input  logic             flag_clr,
  output logic             rst_req,
  output logic             wake_req,
  output logic             timeout_flag,
  output logic             osc_en
);

  clr_src_t src;
  logic     run;
  logic     clr_ext;
  logic     clr_cnt;
  logic     tick;
  logic     post_hit;
  logic     expire;

  assign src.soft_clr = clr_strobe;
  assign src.sleep_in = sleep_enter;
  assign src.osc_fail = clk_fail;
  assign clr_ext      = any_clear(src);

  // An external restart on the expiry edge wins over the timeout.
  assign expire  = run & ~clr_ext & post_hit;
  assign clr_cnt = clr_ext | ~run | expire;
  assign osc_en  = run;

  wdt_enable_ctl i_en (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .sw_en  (sw_en),
    .run    (run)
  );

  wdt_base_div #(.BASE_LOG2(BASE_LOG2)) i_base (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr_cnt),
    .tick (tick)
  );

  wdt_postscaler #(.SEL_W(SEL_W)) i_post (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_cnt),
    .tick    (tick),
    .tap_sel (tap_sel),
    .hit     (post_hit)
  );

  wdt_event_gen i_evt (
    .clk          (clk),
    .rst          (rst),
    .rst_src_wdt  (rst_src_wdt),
    .expire       (expire),
    .in_sleep     (in_sleep),
    .flag_clr     (flag_clr),
    .rst_req      (rst_req),
    .wake_req     (wake_req),
    .timeout_flag (timeout_flag)
  );

  // R2: a disabled watchdog raises nothing in the next cycle.
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !osc_en |=> (!rst_req && !wake_req)) else $error("request while disabled");
  // R6: a clock failure suppresses requests.
  p_clkfail_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    clk_fail |=> (!rst_req && !wake_req)) else $error("request during clock failure");
  // R12: a clear on the expiry edge suppresses the request.
  p_clr_wins_r12: assert property (@(posedge clk) disable iff (rst)
    clr_strobe |=> (!rst_req && !wake_req)) else $error("request despite clear");

endmodule

// File: tb/test_lfo_watchdog.sv
module test_lfo_watchdog;

  localparam int BL = 2;
  localparam int SW = 2;
  localparam int B  = 1 << BL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_src_wdt = 1'b0;
  logic cfg_en = 1'b0, sw_en = 1'b0;
  logic [SW-1:0] tap_sel = '0;
  logic clr_strobe = 1'b0, sleep_enter = 1'b0, clk_fail = 1'b0;
  logic in_sleep = 1'b0, flag_clr = 1'b0;
  logic rst_req, wake_req, timeout_flag, osc_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lfo_watchdog #(.BASE_LOG2(BL), .SEL_W(SW)) i_lfo_watchdog (
    .clk(clk), .rst(rst), .rst_src_wdt(rst_src_wdt), .cfg_en(cfg_en),
    .sw_en(sw_en), .tap_sel(tap_sel), .clr_strobe(clr_strobe),
    .sleep_enter(sleep_enter), .clk_fail(clk_fail), .in_sleep(in_sleep),
    .flag_clr(flag_clr), .rst_req(rst_req), .wake_req(wake_req),
    .timeout_flag(timeout_flag), .osc_en(osc_en)
  );

  function automatic int per(input int s);
    return B << s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Index 0 is the current half cycle after the restart edge.
  task automatic expect_window(input int p, input bit slp, input int n, input string tag);
    for (int i = 0; i <= n; i++) begin
      if (i > 0) step();
      chk(rst_req == (i > 0 && i % p == 0 && !slp), tag, int'(rst_req),
          int'(i > 0 && i % p == 0 && !slp));
      chk(wake_req == (i > 0 && i % p == 0 && slp), tag, int'(wake_req),
          int'(i > 0 && i % p == 0 && slp));
    end
  endtask

  task automatic strobe_clear();
    clr_strobe = 1'b1;
    step();
    clr_strobe = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R11 reset state
    @(negedge clk);
    repeat (3) step();
    chk(rst_req == 1'b0, "R11 reset rst_req", int'(rst_req), 0);
    chk(wake_req == 1'b0, "R11 reset wake_req", int'(wake_req), 0);
    chk(osc_en == 1'b0, "R11 reset osc_en", int'(osc_en), 0);
    chk(timeout_flag == 1'b0, "R11 reset flag", int'(timeout_flag), 0);
    rst = 1'b0;

    // R2 disabled: nothing happens
    for (int i = 0; i < 40; i++) begin
      step();
      chk(!rst_req && !wake_req, "R2 disabled quiet", int'(rst_req | wake_req), 0);
    end
    chk(osc_en == 1'b0, "R1 disabled osc_en", int'(osc_en), 0);

    // R1/R3 enable via configuration
    cfg_en = 1'b1;
    step();
    chk(osc_en == 1'b1, "R1 cfg enable", int'(osc_en), 1);
    expect_window(per(0), 1'b0, 12, "R3 first period after enable");

    // R3 R7 R8 sweep of all codes, awake and asleep
    for (int s = 0; s < (1 << SW); s++) begin
      for (int slp = 0; slp < 2; slp++) begin
        tap_sel  = SW'(s);
        in_sleep = slp[0];
        strobe_clear();
        expect_window(per(s), slp[0], 2 * per(s) + 1, "R3 R7 R8 sweep");
      end
    end
    chk(timeout_flag == 1'b1, "R10 flag after sweep", int'(timeout_flag), 1);

    // R1 software enable alone
    in_sleep = 1'b0;
    tap_sel  = SW'(1);
    cfg_en   = 1'b0;
    step();
    step();
    chk(osc_en == 1'b0, "R1 both off", int'(osc_en), 0);
    sw_en = 1'b1;
    step();
    chk(osc_en == 1'b1, "R1 sw enable", int'(osc_en), 1);
    expect_window(per(1), 1'b0, 2 * per(1), "R1 sw enabled period");

    // R1 software cannot disable when configuration enables
    cfg_en = 1'b1;
    step();
    sw_en = 1'b0;
    step();
    chk(osc_en == 1'b1, "R1 sw cannot disable", int'(osc_en), 1);
    strobe_clear();
    expect_window(per(1), 1'b0, per(1) + 2, "R1 still running");

    // R9 select change mid-period
    tap_sel = SW'(3);
    strobe_clear();
    for (int i = 1; i <= 44; i++) begin
      step();
      if (i == 5) tap_sel = SW'(0);
      chk(rst_req == (i == 32 || i == 36 || i == 40 || i == 44), "R9 deferred select",
          int'(rst_req), int'(i == 32 || i == 36 || i == 40 || i == 44));
    end

    // R4 clear restarts
    tap_sel = SW'(2);
    strobe_clear();
    expect_window(per(2), 1'b0, 10, "R4 before clear");
    strobe_clear();
    expect_window(per(2), 1'b0, 20, "R4 after clear");

    // R5 sleep entry restarts
    strobe_clear();
    expect_window(per(2), 1'b0, 10, "R5 before sleep entry");
    sleep_enter = 1'b1;
    step();
    sleep_enter = 1'b0;
    expect_window(per(2), 1'b0, 20, "R5 after sleep entry");

    // R6 clock failure holds counters
    tap_sel = SW'(0);
    strobe_clear();
    expect_window(per(0), 1'b0, 3, "R6 before fail");
    clk_fail = 1'b1;
    for (int i = 0; i < 30; i++) begin
      step();
      chk(!rst_req && !wake_req, "R6 clock fail quiet", int'(rst_req | wake_req), 0);
    end
    clk_fail = 1'b0;
    expect_window(per(0), 1'b0, 9, "R6 after fail");

    // R12 clear on the expiry edge
    strobe_clear();
    expect_window(per(0), 1'b0, 3, "R12 setup");
    clr_strobe = 1'b1;
    step();
    clr_strobe = 1'b0;
    expect_window(per(0), 1'b0, 8, "R12 clear wins");

    // R10 flag clear and priority
    chk(timeout_flag == 1'b1, "R10 sticky", int'(timeout_flag), 1);
    cfg_en = 1'b0;
    step();
    step();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk(timeout_flag == 1'b0, "R10 flag_clr", int'(timeout_flag), 0);
    repeat (5) step();
    chk(timeout_flag == 1'b0, "R10 stays clear", int'(timeout_flag), 0);
    cfg_en = 1'b1;
    step();
    expect_window(per(0), 1'b0, 3, "R10 run");
    chk(timeout_flag == 1'b0, "R10 before expiry", int'(timeout_flag), 0);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk(timeout_flag == 1'b1, "R10 set beats clear", int'(timeout_flag), 1);
    chk(rst_req == 1'b1, "R10 request with flag", int'(rst_req), 1);
    rst = 1'b1;
    rst_src_wdt = 1'b1;
    step();
    chk(timeout_flag == 1'b1, "R10 held on watchdog reset", int'(timeout_flag), 1);
    chk(!rst_req && !wake_req, "R11 reqs cleared", int'(rst_req | wake_req), 0);
    rst_src_wdt = 1'b0;
    step();
    chk(timeout_flag == 1'b0, "R10 cleared on other reset", int'(timeout_flag), 0);
    rst = 1'b0;

    // R11 reset mid-count
    tap_sel = SW'(1);
    step();
    expect_window(per(1), 1'b0, 5, "R11 before reset");
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(osc_en == 1'b0, "R11 enable cleared", int'(osc_en), 0);
    step();
    expect_window(per(1), 1'b0, 2 * per(1) + 1, "R11 after reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule